// File: doc/BRIEF.md
# Even-Ratio Serial Bit Clock Divider

This block makes the serial bit clock for an audio serial port that drives its own clock. It takes one of two source clocks, the internal bus clock or an external audio clock, and divides it by an even ratio. A 6-bit field sets the ratio. The field counts half-periods: each output half-period lasts as many source cycles as the field value, so the divisor is twice the field and the duty cycle is always 50%. A field value of zero is a bypass, and the selected source clock is forwarded unchanged.

The block also gives downstream logic a bit-rate strobe in the source clock domain. In divide mode the strobe is high for the single source cycle that begins with each rising edge of the output clock. In bypass it stays high, because every source cycle is a bit.

The ratio and the source selection are captured only at the start of an output period, so a change made while the clock runs never shortens a pulse. While the enable is low the output rests low and the divider is cleared.

Top module: `evenratio_sck_div`

## Requirements
- R1: For a ratio field N from 1 to 63, the output clock is high for exactly N source cycles and then low for exactly N source cycles, repeating.
- R2: For a ratio field of 0, while enabled, the output clock follows the selected source clock edge for edge, with the same high and low times.
- R3: src_sel = 0 selects clk_bus as the source and src_sel = 1 selects clk_ext. The output timing of R1 and R2 is measured in cycles of the selected clock.
- R4: A ratio change made while the output clock runs leaves the current output period (its high and low halves) at the old length. The new half-period applies from the next rising edge of the output clock.
- R5: While rst_n is low, sck_out and bit_stb are 0. While en is low, sck_out holds 0 and bit_stb is 0.
- R6: In divide mode (N ≥ 1), bit_stb is high for exactly one source cycle per output period: the cycle that begins at the rising edge of sck_out.
- R7: In bypass mode (N = 0), bit_stb is high in every source cycle once the output is running.
- R8: After en falls, sck_out is low within three source cycles and stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Internal bus clock, the source when src_sel = 0 |
| clk_ext | input | 1 | External audio clock, the source when src_sel = 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Source select: 0 = bus clock, 1 = external clock |
| ratio | input | 6 | Half-period length in source cycles; 0 = bypass |
| en | input | 1 | Runs the divider while high; output rests low while low |
| sck_out | output | 1 | Divided (or bypassed) serial bit clock |
| bit_stb | output | 1 | One-source-cycle strobe per output rising edge; held high in bypass |

## Verification
Suppose the half-period counter runs one step long or short, or misses its terminal value. The very next output edge then lands at the wrong time, and a single high or low measurement shows it within one output period. A ratio register that is reloaded outside the period boundary changes the length of the half-period already in progress, so the mid-period change test sees a wrong high time at once. If the strobe register or the bypass gate holds a wrong state, the strobe count taken over a fixed window of source cycles comes out wrong, and a stuck or late idle state shows as a high output three cycles after the enable drops.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;

  localparam int unsigned RATIO_W = 6;

  typedef logic [RATIO_W-1:0] ratio_t;

  // A field value of zero selects the pass-through path.
  function automatic logic is_bypass(input ratio_t r);
    return (r == '0);
  endfunction

  // Source cycles in one output half-period for a non-zero field.
  function automatic int unsigned half_len(input ratio_t r);
    return int'(r);
  endfunction

  // True on the final source cycle of a half-period.
  function automatic logic at_half_end(input ratio_t cnt, input ratio_t r);
    return (r != '0) && ({1'b0, cnt} + 1'b1 == {1'b0, r});
  endfunction

endpackage

// File: rtl/sckdiv_src_mux.sv
module sckdiv_src_mux (
  input  logic sel,
  input  logic clk_a,
  input  logic clk_b,
  output logic clk_o
);
  assign clk_o = sel ? clk_b : clk_a;
endmodule

// File: rtl/sckdiv_half_counter.sv
module sckdiv_half_counter
  import sckdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   sel_in,
  input  ratio_t ratio_in,
  output logic   sel_q,
  output logic   run_q,
  output ratio_t ratio_q,
  output logic   div_q,
  output logic   stb_q
);
  ratio_t cnt_q;
  logic   half_end;
  logic   rise_evt;

  assign half_end = at_half_end(cnt_q, ratio_q);
  assign rise_evt = run_q && half_end && !div_q && !is_bypass(ratio_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sel_q   <= 1'b0;
      ratio_q <= '0;
      cnt_q   <= '0;
      div_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      run_q <= en;
      stb_q <= rise_evt;
      if (!run_q || is_bypass(ratio_q)) begin
        cnt_q   <= '0;
        div_q   <= 1'b0;
        ratio_q <= ratio_in;
        sel_q   <= sel_in;
      end else if (half_end) begin
        cnt_q <= '0;
        if (div_q) begin
          div_q <= 1'b0;
        end else begin
          ratio_q <= ratio_in;
          sel_q   <= sel_in;
          div_q   <= !is_bypass(ratio_in);
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sckdiv_out_stage.sv
module sckdiv_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass_req,
  input  logic div_in,
  input  logic stb_in,
  output logic sck_o,
  output logic stb_o
);
  logic byp_q;

  // Updated on the falling edge so the path switch happens while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= bypass_req;
  end

  assign sck_o = byp_q ? clk : div_in;
  assign stb_o = byp_q | stb_in;
endmodule

// File: rtl/evenratio_sck_div.sv
module evenratio_sck_div
  import sckdiv_pkg::*;
(
  input  logic               clk_bus,
  input  logic               clk_ext,
  input  logic               rst_n,
  input  logic               src_sel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               en,
  output logic               sck_out,
  output logic               bit_stb
);
  logic   src_clk;
  logic   sel_q;
  logic   run_q;
  ratio_t ratio_q;
  logic   div_q;
  logic   stb_q;
  logic   bypass_req;

  sckdiv_src_mux i_mux (
    .sel   (sel_q),
    .clk_a (clk_bus),
    .clk_b (clk_ext),
    .clk_o (src_clk)
  );

  sckdiv_half_counter i_cnt (
    .clk      (src_clk),
    .rst_n    (rst_n),
    .en       (en),
    .sel_in   (src_sel),
    .ratio_in (ratio),
    .sel_q    (sel_q),
    .run_q    (run_q),
    .ratio_q  (ratio_q),
    .div_q    (div_q),
    .stb_q    (stb_q)
  );

  assign bypass_req = run_q && is_bypass(ratio_q);

  sckdiv_out_stage i_out (
    .clk        (src_clk),
    .rst_n      (rst_n),
    .bypass_req (bypass_req),
    .div_in     (div_q),
    .stb_in     (stb_q),
    .sck_o      (sck_out),
    .stb_o      (bit_stb)
  );
endmodule

// File: rtl/sckdiv_checker.sv
module sckdiv_checker
  import sckdiv_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   run_q,
  input ratio_t ratio_q,
  input ratio_t cnt_q,
  input logic   div_q,
  input logic   stb_q
);
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ratio_q != '0) |-> (cnt_q < ratio_q));

  assert_toggle_at_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && div_q != $past(div_q))
      |-> ({1'b0, $past(cnt_q)} + 1'b1 == {1'b0, $past(ratio_q)}));

  assert_ratio_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $past(ratio_q) != '0 && !$rose(div_q) && ratio_q != '0)
      |-> (ratio_q == $past(ratio_q)));

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !div_q);

  assert_stb_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> stb_q);

  assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
endmodule

bind sckdiv_half_counter sckdiv_checker i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_q   (run_q),
  .ratio_q (ratio_q),
  .cnt_q   (cnt_q),
  .div_q   (div_q),
  .stb_q   (stb_q)
);

// File: tb/test_evenratio_sck_div.sv
`timescale 1ns/1ps
module test_evenratio_sck_div;
  localparam real TBUS = 4.0;
  localparam real TEXT = 6.0;

  logic clk_bus = 1'b0, clk_ext = 1'b0, rst_n = 1'b0;
  logic src_sel = 1'b0, en = 1'b0;
  logic [5:0] ratio = 6'd0;
  logic sck_out, bit_stb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(TBUS/2) clk_bus = ~clk_bus;
  always #(TEXT/2) clk_ext = ~clk_ext;

  evenratio_sck_div i_evenratio_sck_div (
    .clk_bus(clk_bus), .clk_ext(clk_ext), .rst_n(rst_n), .src_sel(src_sel),
    .ratio(ratio), .en(en), .sck_out(sck_out), .bit_stb(bit_stb));

  function automatic bit near(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic chk_real(string req, string what, real act, real exp);
    checks++;
    if (!near(act, exp)) begin
      errors++;
      $display("FAIL %s %s actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic src_neg(input bit s, input int n);
    for (int i = 0; i < n; i++) begin
      if (s) @(negedge clk_ext); else @(negedge clk_bus);
    end
  endtask

  task automatic start(input bit s, input int k);
    en = 1'b0;
    src_neg(src_sel, 4);
    src_sel = s;
    ratio = 6'(k);
    src_neg(s, 4);
    en = 1'b1;
  endtask

  // R1 R2 R3 R6 R7: half-period times and strobe count for one setting
  task automatic measure(input bit s, input int k);
    real t0, t1, t2, tsrc, exp;
    int cnt;
    string req;
    tsrc = s ? TEXT : TBUS;
    exp  = (k == 0) ? tsrc / 2.0 : k * tsrc;
    req  = (k == 0) ? "R2" : (s ? "R3" : "R1");
    start(s, k);
    @(posedge sck_out); @(posedge sck_out);
    t0 = $realtime;
    @(negedge sck_out); t1 = $realtime;
    @(posedge sck_out); t2 = $realtime;
    chk_real(req, $sformatf("high ratio=%0d sel=%0d", k, s), t1 - t0, exp);
    chk_real(req, $sformatf("low ratio=%0d sel=%0d", k, s), t2 - t1, exp);
    cnt = 0;
    for (int i = 0; i < ((k == 0) ? 4 : 4 * k); i++) begin
      src_neg(s, 1);
      if (bit_stb) cnt++;
    end
    chk_int((k == 0) ? "R7" : "R6", $sformatf("strobe count ratio=%0d sel=%0d", k, s),
            cnt, (k == 0) ? 4 : 2);
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    real t0, t1, t2, t3;
    int hi;
    // R5: reset state
    #13;
    chk_int("R5", "sck_out in reset", int'(sck_out), 0);
    chk_int("R5", "bit_stb in reset", int'(bit_stb), 0);
    rst_n = 1'b1;
    ratio = 6'd3;
    // R5: disabled stays low
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_bus);
      if (sck_out || bit_stb) hi++;
    end
    chk_int("R5", "high samples while disabled", hi, 0);

    for (int k = 0; k < 64; k++) measure(1'b0, k);
    for (int k = 0; k < 64; k++) measure(1'b1, k);

    // R4: ratio change mid-period
    start(1'b0, 5);
    @(posedge sck_out); @(posedge sck_out);
    t0 = $realtime;
    src_neg(1'b0, 2);
    ratio = 6'd3;
    @(negedge sck_out); t1 = $realtime;
    @(posedge sck_out); t2 = $realtime;
    @(negedge sck_out); t3 = $realtime;
    chk_real("R4", "high after change", t1 - t0, 5 * TBUS);
    chk_real("R4", "low after change", t2 - t1, 5 * TBUS);
    chk_real("R4", "next high new ratio", t3 - t2, 3 * TBUS);

    // R8: disable while high
    start(1'b0, 8);
    @(posedge sck_out);
    src_neg(1'b0, 1);
    en = 1'b0;
    src_neg(1'b0, 3);
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      if (sck_out) hi++;
      src_neg(1'b0, 1);
    end
    chk_int("R8", "high samples after disable", hi, 0);

    // R8: disable in bypass
    start(1'b1, 0);
    src_neg(1'b1, 6);
    en = 1'b0;
    src_neg(1'b1, 3);
    hi = 0;
    for (int i = 0; i < 30; i++) begin
      #1.5;
      if (sck_out) hi++;
      src_neg(1'b1, 1);
    end
    chk_int("R8", "high samples after bypass disable", hi, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule